// File: doc/BRIEF.md
# Predicated Segment Load Address Generator

This block turns one vector load command into a stream of single-word load requests. Each request carries a byte address, a field number inside the current segment and the element number it belongs to. A segment is a group of one or more consecutive fields that are fetched for every element. The fields of one element go to consecutive destination registers. The element number selects the slot inside those registers.

Three addressing forms are supported. In unit-stride form the stride is the element size. In constant-stride form the stride comes from a scalar register value. In indexed form, which the issuing stage selects when the offset operand is a vector, each element's offset is read from an offset source. The block names the element it is asking about, and the source answers in the same cycle.

An optional predicate word removes elements from the stream. Removed elements cost no request and no idle cycle. A single-cycle completion pulse follows the last accepted request.

Top module: `seg_agen`

## Requirements
- R1: After a synchronous active-low reset, `req_valid`, `busy` and `done` are low, and they stay low until `start` is seen.
- R2: With `unit_stride` high, the stride is `elem_size`. Field j of element i is then at `base_addr + i*(seg_last+1)*elem_size + j*elem_size`.
- R3: With `unit_stride` low and `indexed` low, the stride is `stride_val`. The element offset is `i*(seg_last+1)*stride_val`.
- R4: Requests are ordered by element, ascending. Within each element, fields run from j=0 to j=`seg_last` inclusive. `req_field` carries j, `req_elem` carries i, and `req_addr` is base plus element offset plus j times stride.
- R5: With `indexed` high, the element offset is `off_val` while `off_elem` equals i. The field term j times stride is still added.
- R6: With `pred_en` high, element i (i < `vec_len`) is requested only when `pred_word[i]` XOR `pred_inv` is 1. Bit i of `pred_word` belongs to element i.
- R7: With `pred_en` low, every element from 0 to `vec_len-1` is requested, whatever `pred_word` and `pred_inv` hold.
- R8: All address sums and products are taken modulo 2^AW.
- R9: While `req_valid` is high and `req_ready` is low, the request stays valid and `req_addr`, `req_field` and `req_elem` do not change. A request is consumed on a cycle where both are high.
- R10: `done` is high for exactly one cycle. That cycle is the one after the last request is accepted. If no element is enabled (including `vec_len`=0), `done` rises two cycles after `start` and no request is issued.
- R11: `start` has no effect while `busy` is high. The command in flight keeps its captured base, stride, length, segment and predicate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture the command and begin (ignored while busy) |
| base_addr | input | AW | Base byte address |
| elem_size | input | AW | Element size in bytes (unit-stride stride) |
| stride_val | input | AW | Scalar stride value (constant-stride) |
| unit_stride | input | 1 | 1: stride is elem_size, 0: stride is stride_val |
| seg_last | input | SEGW | Index of the last field in a segment (fields = seg_last+1) |
| vec_len | input | IW+1 | Number of elements, 0 to MAX_VL |
| pred_en | input | 1 | Enable predication |
| pred_inv | input | 1 | Invert predicate bits |
| pred_word | input | MAX_VL | Predicate bits, bit i for element i |
| indexed | input | 1 | Use per-element offsets from off_val |
| off_elem | output | IW | Element whose offset is being read |
| off_val | input | AW | Offset of element off_elem (same cycle) |
| req_valid | output | 1 | Load request present |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | AW | Byte address of the request |
| req_field | output | SEGW | Field j, destination register offset |
| req_elem | output | IW | Element index i |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two things can happen in the same clock edge: the last field of one element is accepted, and the scan jumps over any run of disabled elements to the next enabled one. Sparse predicate words with gaps of several elements provoke this, including an inverted case. Ready is toggled in a pattern so that some final-field handshakes fall on stalled cycles and others do not. The check is that the request accepted after each final field carries the next enabled element and field 0, with no idle cycle between the two.

// File: rtl/seg_agen_pkg.sv
// Shared types for the segment load address generator.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package seg_agen_pkg;

    // Sequencer states: waiting, first-element search, issuing requests.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_RUN  = 2'd2
    } agen_state_e;

endpackage

// File: rtl/seg_agen_mask.sv
// Builds the per-element enable mask from length and predicate inputs.
// Assumes: evaluated only in the cycle the command is captured.
module seg_agen_mask #(
    parameter int MAX_VL = 16,
    parameter int VLW    = 5
) (
    input  logic [VLW-1:0]    vec_len,
    input  logic              pred_en,
    input  logic              pred_inv,
    input  logic [MAX_VL-1:0] pred_word,
    output logic [MAX_VL-1:0] mask
);

    // One enable bit per element: inside the length and passing the predicate.
    for (genvar k = 0; k < MAX_VL; k++) begin : g_bit
        assign mask[k] = (VLW'(k) < vec_len) &&
                         (!pred_en || (pred_word[k] ^ pred_inv));
    end

endmodule

// File: rtl/seg_agen_find.sv
// Finds the lowest enabled element at or above a starting index.
// Assumes: from_idx may equal MAX_VL, which yields found = 0.
module seg_agen_find #(
    parameter int MAX_VL = 16,
    parameter int IW     = 4,
    parameter int VLW    = 5
) (
    input  logic [MAX_VL-1:0] mask,
    input  logic [VLW-1:0]    from_idx,
    output logic              found,
    output logic [IW-1:0]     next_idx
);

    // Descending scan so the lowest qualifying element is the last to write.
    always_comb begin
        found    = 1'b0;
        next_idx = '0;
        for (int k = MAX_VL - 1; k >= 0; k--) begin
            if (mask[k] && (VLW'(k) >= from_idx)) begin
                found    = 1'b1;
                next_idx = IW'(k);
            end
        end
    end

endmodule

// File: rtl/seg_agen_addr.sv
// Computes the byte address of one field of one element.
// Assumes: all arithmetic wraps at AW bits; off_val is valid in the same cycle.
module seg_agen_addr #(
    parameter int AW   = 32,
    parameter int IW   = 4,
    parameter int SEGW = 3
) (
    input  logic [AW-1:0]   base,
    input  logic [AW-1:0]   stride,
    input  logic [SEGW-1:0] seg_last,
    input  logic            indexed,
    input  logic [AW-1:0]   off_val,
    input  logic [IW-1:0]   elem,
    input  logic [SEGW-1:0] field,
    output logic [AW-1:0]   addr
);

    logic [AW-1:0] fields_n;
    logic [AW-1:0] span;
    logic [AW-1:0] lin_off;
    logic [AW-1:0] elem_off;
    logic [AW-1:0] fld_off;

    // Element offset (linear or indexed) plus field offset, modulo 2^AW.
    always_comb begin
        fields_n = AW'(seg_last) + AW'(1);
        span     = stride * fields_n;
        lin_off  = span * AW'(elem);
        elem_off = indexed ? off_val : lin_off;
        fld_off  = stride * AW'(field);
        addr     = base + elem_off + fld_off;
    end

endmodule

// File: rtl/seg_agen.sv
// Top: sequences fields and enabled elements of one vector load command and
// presents each as a request held until accepted.
// Assumes: command inputs are sampled only on an accepted start; off_val
// answers off_elem combinationally.
module seg_agen #(
    parameter int AW     = 32,
    parameter int MAX_VL = 16,
    parameter int SEGW   = 3,
    parameter int IW     = $clog2(MAX_VL),
    parameter int VLW    = IW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     base_addr,
    input  logic [AW-1:0]     elem_size,
    input  logic [AW-1:0]     stride_val,
    input  logic              unit_stride,
    input  logic [SEGW-1:0]   seg_last,
    input  logic [VLW-1:0]    vec_len,
    input  logic              pred_en,
    input  logic              pred_inv,
    input  logic [MAX_VL-1:0] pred_word,
    input  logic              indexed,
    output logic [IW-1:0]     off_elem,
    input  logic [AW-1:0]     off_val,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [AW-1:0]     req_addr,
    output logic [SEGW-1:0]   req_field,
    output logic [IW-1:0]     req_elem,
    output logic              busy,
    output logic              done
);
    import seg_agen_pkg::*;

    agen_state_e       state_q;
    logic [IW-1:0]     cur_i_q;
    logic [SEGW-1:0]   cur_j_q;
    logic [AW-1:0]     base_q;
    logic [AW-1:0]     stride_q;
    logic [SEGW-1:0]   seg_q;
    logic              idx_q;
    logic [MAX_VL-1:0] mask_q;
    logic              done_q;

    logic [MAX_VL-1:0] mask_in;
    logic [VLW-1:0]    from_idx;
    logic              found;
    logic [IW-1:0]     next_idx;
    logic              last_fld;

    seg_agen_mask #(.MAX_VL(MAX_VL), .VLW(VLW)) u_mask (
        .vec_len   (vec_len),
        .pred_en   (pred_en),
        .pred_inv  (pred_inv),
        .pred_word (pred_word),
        .mask      (mask_in)
    );

    // Search start: element 0 after capture, the element after the current one while running.
    always_comb begin
        from_idx = (state_q == ST_RUN) ? (VLW'(cur_i_q) + VLW'(1)) : '0;
        last_fld = (cur_j_q == seg_q);
    end

    seg_agen_find #(.MAX_VL(MAX_VL), .IW(IW), .VLW(VLW)) u_find (
        .mask     (mask_q),
        .from_idx (from_idx),
        .found    (found),
        .next_idx (next_idx)
    );

    seg_agen_addr #(.AW(AW), .IW(IW), .SEGW(SEGW)) u_addr (
        .base     (base_q),
        .stride   (stride_q),
        .seg_last (seg_q),
        .indexed  (idx_q),
        .off_val  (off_val),
        .elem     (cur_i_q),
        .field    (cur_j_q),
        .addr     (req_addr)
    );

    // Sequencer: capture command, walk fields, jump to next enabled element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cur_i_q  <= '0;
            cur_j_q  <= '0;
            base_q   <= '0;
            stride_q <= '0;
            seg_q    <= '0;
            idx_q    <= 1'b0;
            mask_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        base_q   <= base_addr;
                        stride_q <= unit_stride ? elem_size : stride_val;
                        seg_q    <= seg_last;
                        idx_q    <= indexed;
                        mask_q   <= mask_in;
                        state_q  <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (found) begin
                        cur_i_q <= next_idx;
                        cur_j_q <= '0;
                        state_q <= ST_RUN;
                    end else begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_RUN: begin
                    if (req_ready) begin
                        if (!last_fld) begin
                            cur_j_q <= cur_j_q + SEGW'(1);
                        end else if (found) begin
                            cur_i_q <= next_idx;
                            cur_j_q <= '0;
                        end else begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output view of the sequencer state.
    always_comb begin
        req_valid = (state_q == ST_RUN);
        req_field = cur_j_q;
        req_elem  = cur_i_q;
        off_elem  = cur_i_q;
        busy      = (state_q != ST_IDLE);
        done      = done_q;
    end

endmodule

// File: rtl/seg_agen_chk.sv
// Protocol checker for seg_agen, attached by bind.
// Assumes: mask is the captured enable mask of the command in flight.
module seg_agen_chk #(
    parameter int AW     = 32,
    parameter int MAX_VL = 16,
    parameter int SEGW   = 3,
    parameter int IW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [AW-1:0]     req_addr,
    input logic [SEGW-1:0]   req_field,
    input logic [IW-1:0]     req_elem,
    input logic              busy,
    input logic              done,
    input logic [MAX_VL-1:0] mask
);

    // A stalled request keeps its contents.
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
            (req_valid && $stable(req_addr) && $stable(req_field) && $stable(req_elem)));

    // Completion is a single-cycle pulse.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Completion only ends a command that was in progress.
    assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // No request outside a command.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid);

    // Only enabled elements are requested.
    assert_pred_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> mask[req_elem]);

    // Within an element the accepted field steps by one.
    assert_field_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=>
            (!req_valid || (req_elem != $past(req_elem)) ||
             (req_field == $past(req_field) + SEGW'(1))));

endmodule

bind seg_agen seg_agen_chk #(
    .AW(AW), .MAX_VL(MAX_VL), .SEGW(SEGW), .IW(IW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_field (req_field),
    .req_elem  (req_elem),
    .busy      (busy),
    .done      (done),
    .mask      (mask_q)
);

// File: tb/tb_seg_agen.sv
// Self-checking bench for seg_agen: vector table walk plus directed cases.
module tb_seg_agen;

    localparam int AW = 32;
    localparam int MAX_VL = 16;
    localparam int SEGW = 3;
    localparam int IW = 4;
    localparam int VLW = 5;

    typedef struct packed {
        logic        unit;
        logic        idx;
        logic        pen;
        logic        pinv;
        logic [15:0] pw;
        logic [4:0]  vl;
        logic [2:0]  seg;
        logic [31:0] base;
        logic [31:0] es;
        logic [31:0] sr;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 5'd4,  3'd0, 32'h0000_1000, 32'd4, 32'd0},  // R2 R7
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF, 5'd3,  3'd2, 32'h0000_2000, 32'd4, 32'h10}, // R3 R4 R7
        '{1'b1, 1'b0, 1'b1, 1'b0, 16'hA609, 5'd16, 3'd1, 32'h0000_3000, 32'd8, 32'd0},  // R6
        '{1'b0, 1'b0, 1'b1, 1'b1, 16'hA609, 5'd10, 3'd0, 32'h0000_4000, 32'd4, 32'd12}, // R6 inverted
        '{1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 5'd5,  3'd1, 32'h0000_5000, 32'd2, 32'd0},  // R5
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 5'd4,  3'd1, 32'hFFFF_FFF8, 32'd4, 32'd8},  // R8
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 5'd0,  3'd3, 32'h0000_6000, 32'd4, 32'd0},  // R10 empty
        '{1'b1, 1'b0, 1'b1, 1'b0, 16'hFF00, 5'd8,  3'd0, 32'h0000_7000, 32'd4, 32'd0},  // R10 none enabled
        '{1'b0, 1'b0, 1'b1, 1'b1, 16'h5555, 5'd16, 3'd7, 32'h0000_8000, 32'd4, 32'd4}   // R4 R6 full segment
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [AW-1:0]     base_addr = '0;
    logic [AW-1:0]     elem_size = '0;
    logic [AW-1:0]     stride_val = '0;
    logic              unit_stride = 1'b0;
    logic [SEGW-1:0]   seg_last = '0;
    logic [VLW-1:0]    vec_len = '0;
    logic              pred_en = 1'b0;
    logic              pred_inv = 1'b0;
    logic [MAX_VL-1:0] pred_word = '0;
    logic              indexed = 1'b0;
    logic [IW-1:0]     off_elem;
    logic [AW-1:0]     off_val;
    logic              req_valid;
    logic              req_ready = 1'b0;
    logic [AW-1:0]     req_addr;
    logic [SEGW-1:0]   req_field;
    logic [IW-1:0]     req_elem;
    logic              busy;
    logic              done;

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [31:0] exp_addr [0:127];
    int          exp_i    [0:127];
    int          exp_j    [0:127];
    int          n_exp;

    seg_agen #(.AW(AW), .MAX_VL(MAX_VL), .SEGW(SEGW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .elem_size(elem_size), .stride_val(stride_val), .unit_stride(unit_stride),
        .seg_last(seg_last), .vec_len(vec_len), .pred_en(pred_en),
        .pred_inv(pred_inv), .pred_word(pred_word), .indexed(indexed),
        .off_elem(off_elem), .off_val(off_val), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_field(req_field),
        .req_elem(req_elem), .busy(busy), .done(done)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Offset source for indexed mode: irregular, partly descending values.
    function automatic logic [31:0] off_fn(input int i);
        return 32'h300 - 32'(i) * 32'h24 + ((i % 2 == 1) ? 32'h1000 : 32'h0);
    endfunction

    assign off_val = off_fn(int'(off_elem));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference sequence from a vector record.
    task automatic build_exp(input vec_t c);
        logic [31:0] st;
        logic [31:0] eoff;
        bit en;
        st = c.unit ? c.es : c.sr;
        n_exp = 0;
        for (int i = 0; i < int'(c.vl); i++) begin
            en = !c.pen || (c.pw[i] ^ c.pinv);
            if (en) begin
                eoff = c.idx ? off_fn(i) : 32'(i) * (32'(c.seg) + 32'd1) * st;
                for (int j = 0; j <= int'(c.seg); j++) begin
                    exp_addr[n_exp] = c.base + eoff + 32'(j) * st;
                    exp_i[n_exp] = i;
                    exp_j[n_exp] = j;
                    n_exp++;
                end
            end
        end
    endtask

    // Run one command; poke drives a second start while busy (R11).
    task automatic run_vec(input int v, input vec_t c, input bit poke, input string tag);
        int got;
        bit stall_prev;
        logic [31:0] hold_a;
        logic [2:0] hold_f;
        logic [3:0] hold_e;
        bit saw_done;
        int guard;
        build_exp(c);
        @(negedge clk);
        unit_stride = c.unit; indexed = c.idx; pred_en = c.pen; pred_inv = c.pinv;
        pred_word = c.pw; vec_len = c.vl; seg_last = c.seg; base_addr = c.base;
        elem_size = c.es; stride_val = c.sr; start = 1'b1;
        got = 0; stall_prev = 0; saw_done = 0; guard = 0;
        hold_a = '0; hold_f = '0; hold_e = '0;
        while (!saw_done && guard < 2000) begin
            @(negedge clk);
            guard++;
            start = 1'b0;
            if (poke && guard == 3) begin
                start = 1'b1;
                base_addr = 32'hDEAD_0000;
                vec_len = 5'd1;
                seg_last = 3'd0;
            end
            req_ready = ((cyc + v) % 3) != 0;
            if (stall_prev) begin
                check(req_valid && req_addr == hold_a && req_field == hold_f &&
                      req_elem == hold_e, "R9", "held request", req_addr, hold_a);
            end
            if (done) begin
                saw_done = 1;
                check(got == n_exp && !req_valid, "R10", {tag, " done after last"},
                      32'(got), 32'(n_exp));
            end else if (req_valid) begin
                if (got >= n_exp) begin
                    check(0, tag, "extra request", 32'(got), 32'(n_exp));
                end else if (req_ready) begin
                    check(req_addr == exp_addr[got], tag, "address", req_addr, exp_addr[got]);
                    check(int'(req_elem) == exp_i[got] && int'(req_field) == exp_j[got],
                          tag, "elem/field", {24'h0, req_elem, 1'b0, req_field},
                          {24'h0, 4'(exp_i[got]), 1'b0, 3'(exp_j[got])});
                    got++;
                end
            end
            stall_prev = req_valid && !req_ready && !done;
            hold_a = req_addr; hold_f = req_field; hold_e = req_elem;
        end
        check(saw_done, "R10", {tag, " done seen"}, 32'(saw_done), 32'd1);
        @(negedge clk);
        check(!done && !busy, "R10", "single-cycle done", {30'h0, done, busy}, 32'h0);
        req_ready = 1'b0;
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        wait (cyc > 50000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected below 50000", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!req_valid && !busy && !done, "R1", "reset outputs",
              {29'h0, req_valid, busy, done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!req_valid && !busy && !done, "R1", "idle without start",
              {29'h0, req_valid, busy, done}, 32'h0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R10
        for (int v = 0; v < NV; v++) begin
            run_vec(v, VECS[v], 1'b0, $sformatf("R4/vec%0d", v));
        end

        // R7: predicate bits ignored when predication is off
        begin
            vec_t c;
            c = VECS[0];
            c.pw = 16'h0000; c.pinv = 1'b1; c.vl = 5'd6;
            run_vec(20, c, 1'b0, "R7");
        end

        // R11: start while busy does not disturb the command in flight
        run_vec(1, VECS[1], 1'b1, "R11");
        @(negedge clk);
        check(!busy && !req_valid, "R11", "no second command",
              {30'h0, busy, req_valid}, 32'h0);

        // R1: reset in the middle of a command returns to idle
        @(negedge clk);
        unit_stride = 1'b1; pred_en = 1'b0; vec_len = 5'd8; seg_last = 3'd2;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!req_valid && !busy && !done, "R1", "reset mid-command",
              {29'h0, req_valid, busy, done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule